// File: doc/BRIEF.md
# Packet Container Packing Engine

This block collects received Ethernet frames into fixed 4 KB containers of 1024 words of 32 bits each, so that software or a DMA engine can move many frames in one transfer. Frames arrive one byte per cycle. The first byte carries a start flag and the declared frame length, and the last byte carries an end flag. Each frame is packed into the current container from a word boundary onward. Its byte length is entered in the container's header table at the moment the frame is accepted.

Two containers form a ping-pong pair. When a frame does not fit in the current container, the engine closes that container: it writes the container's summary word, sets its full bit and pulses an interrupt. The frame then goes into the other container, provided that one has been emptied by software. If not, the frame is discarded and a channel-full pulse is raised. Software drains a full container through a registered word read port and hands it back with a clear strobe.

Top module: `pkt_container_packer`

## Requirements
- R1: After reset both full bits are 0, irq_o, ch_full_o and bad_len_o are 0, and the first accepted frame goes to container 0.
- R2: Byte k of an accepted frame is stored at bits 8*(k mod 4)+7 down to 8*(k mod 4) of data word S + k/4, where S is the first free word at the frame start. Data begins at word 34, every frame starts on a new word, and pad bytes in a frame's last word read as 0.
- R3: The length of the i-th frame (from 0) in a container sits in word 1 + i/2. Even i uses bits 31:16 and leaves bits 15:0 at 0 until the next frame arrives. Odd i uses bits 15:0. A container never holds more than 66 frames.
- R4: A frame is accepted while the words used (header included) plus ceil(len/4) stay at or below 1024. A frame that would exceed this limit, or that would be the 67th, closes the container. Closing writes word 0 with the words used in bits 31:16 and the frame count in bits 15:0, and sets the container's full bit.
- R5: irq_o is high for exactly one cycle, the cycle in which the closed container's full bit first reads 1.
- R6: A frame whose declared length is below 64 or above 1538 is discarded. bad_len_o pulses for one cycle, and no container contents, counts or full bits change.
- R7: A legal frame whose target container is full is discarded with a one-cycle ch_full_o pulse. None of its bytes are stored.
- R8: clr_valid with clr_sel clears that container's full bit in the next cycle. A clear given in the same cycle as a frame start that targets that container lets the frame be accepted.
- R9: rd_data returns word rd_addr of container rd_sel one cycle after rd_en.
- R10: Containers are filled in strict alternation 0, 1, 0, ...; a dropped frame does not change the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_byte | input | 8 | Frame byte |
| in_len | input | LW | Declared frame length, sampled with in_sof |
| clr_valid | input | 1 | Software clear strobe |
| clr_sel | input | 1 | Container to clear |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | Container to read |
| rd_addr | input | AW | Word address in container |
| rd_data | output | 32 | Read word, one cycle after rd_en |
| full_o | output | 2 | Full bit per container |
| irq_o | output | 1 | Container-closed pulse |
| ch_full_o | output | 1 | Frame dropped, target full |
| bad_len_o | output | 1 | Frame dropped, illegal length |

## Verification
Two functions can fall on the same frame-start edge: closing the current container and a decision on the other one, which is either a drop because it is still full or a clear from software that arrives in that very cycle. The bench provokes the first case by filling both containers, so that one frame start raises irq_o and ch_full_o together. It provokes the second by issuing the clear strobe together with the closing frame's first byte. The outcome is judged by the pulses, by full_o, and by reading the frame back from the newly cleared container at the expected header and data words.

// File: rtl/pkt_container_packer.sv
module pkt_container_packer #(
  parameter int WORDS  = 1024,
  parameter int HDR    = 34,
  parameter int MAXPK  = 66,
  parameter int MINLEN = 64,
  parameter int MAXLEN = 1538,
  parameter int LW     = 11,
  localparam int AW = $clog2(WORDS),
  localparam int WB = AW + 1,
  localparam int PW = $clog2(MAXPK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_byte,
  input  logic [LW-1:0] in_len,
  input  logic          clr_valid,
  input  logic          clr_sel,
  input  logic          rd_en,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [1:0]    full_o,
  output logic          irq_o,
  output logic          ch_full_o,
  output logic          bad_len_o
);

  logic          cur;
  logic [1:0]    status;
  logic [PW-1:0] pcnt;
  logic [WB-1:0] wcnt;
  logic [AW-1:0] wptr;
  logic [1:0]    lane;
  logic [31:0]   acc;
  logic          rx_on, drop_on;

  logic [15:0] mhi [2*WORDS];
  logic [15:0] mlo [2*WORDS];

  wire [1:0] clr_eff = clr_valid ? (clr_sel ? 2'b10 : 2'b01) : 2'b00;
  wire [1:0] st_eff  = status & ~clr_eff;

  wire sof_ev = in_valid && in_sof && !rx_on && !drop_on;
  wire len_ok = (in_len >= LW'(MINLEN)) && (in_len <= LW'(MAXLEN));
  wire [WB-1:0] nwords = WB'(({1'b0, in_len} + (LW+1)'(3)) >> 2);
  wire fits = (pcnt < PW'(MAXPK)) &&
              (({1'b0, wcnt} + {1'b0, nwords}) <= (WB+1)'(WORDS));

  wire go        = sof_ev && len_ok;
  wire close_now = go && !st_eff[cur] && !fits;
  wire tgt       = close_now ? ~cur : cur;
  wire take_now  = go && !st_eff[tgt];
  wire drop_full = go && st_eff[tgt];

  wire [PW-1:0] base_p = close_now ? '0 : pcnt;
  wire [WB-1:0] base_w = close_now ? WB'(HDR) : wcnt;
  wire [AW-1:0] len_a  = AW'(1 + (base_p >> 1));

  wire          byte_on = in_valid && (rx_on || take_now);
  wire [1:0]    lane_c  = take_now ? 2'd0 : lane;
  wire [31:0]   acc_c   = take_now ? '0 : acc;
  wire [AW-1:0] wa      = take_now ? base_w[AW-1:0] : wptr;
  wire          dw_en   = byte_on && (lane_c == 2'd3 || in_eof);

  logic [31:0] wd;
  always_comb begin
    wd = acc_c;
    wd[8*lane_c +: 8] = in_byte;
  end

  assign full_o = status;

  always_ff @(posedge clk) begin
    if (close_now) begin
      mhi[{cur, AW'(0)}] <= 16'(wcnt);
      mlo[{cur, AW'(0)}] <= 16'(pcnt);
    end
    if (take_now) begin
      if (!base_p[0]) begin
        mhi[{tgt, len_a}] <= 16'(in_len);
        mlo[{tgt, len_a}] <= '0;
      end else begin
        mlo[{tgt, len_a}] <= 16'(in_len);
      end
    end
    if (dw_en) begin
      mhi[{tgt, wa}] <= wd[31:16];
      mlo[{tgt, wa}] <= wd[15:0];
    end
    if (rd_en) rd_data <= {mhi[{rd_sel, rd_addr}], mlo[{rd_sel, rd_addr}]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= 1'b0;
      status    <= '0;
      pcnt      <= '0;
      wcnt      <= WB'(HDR);
      wptr      <= '0;
      lane      <= '0;
      acc       <= '0;
      rx_on     <= 1'b0;
      drop_on   <= 1'b0;
      irq_o     <= 1'b0;
      ch_full_o <= 1'b0;
      bad_len_o <= 1'b0;
    end else begin
      status    <= st_eff | (close_now ? (cur ? 2'b10 : 2'b01) : 2'b00);
      irq_o     <= close_now;
      ch_full_o <= drop_full;
      bad_len_o <= sof_ev && !len_ok;
      if (close_now) cur <= ~cur;
      if (take_now) begin
        pcnt <= base_p + PW'(1);
        wcnt <= base_w + nwords;
      end else if (close_now) begin
        pcnt <= '0;
        wcnt <= WB'(HDR);
      end
      if (byte_on) begin
        if (dw_en) begin
          wptr <= wa + AW'(1);
          lane <= '0;
          acc  <= '0;
        end else begin
          wptr <= wa;
          lane <= lane_c + 2'd1;
          acc  <= wd;
        end
        rx_on <= !in_eof;
      end
      if (sof_ev && !take_now) drop_on <= !in_eof;
      else if (drop_on && in_valid && in_eof) drop_on <= 1'b0;
    end
  end

  AST_IRQ_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) != 2'b00) |-> irq_o); // R5
  AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o || $past(close_now)); // R5
  AST_PKT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PW'(MAXPK)); // R3
  AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WB'(WORDS)); // R4
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en |-> !status[tgt]); // R7
  AST_RX_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_on && drop_on)); // R7
  AST_BADLEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_len_o |-> $stable(pcnt) && $stable(wcnt) && !irq_o); // R6

endmodule

// File: tb/tb_pkt_container_packer.sv
module tb_pkt_container_packer;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_byte;
  logic [10:0] in_len;
  logic        clr_valid, clr_sel;
  logic        rd_en, rd_sel;
  logic [9:0]  rd_addr;
  logic [31:0] rd_data;
  logic [1:0]  full_o;
  logic        irq_o, ch_full_o, bad_len_o;

  pkt_container_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_byte(in_byte), .in_len(in_len), .clr_valid(clr_valid), .clr_sel(clr_sel),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .full_o(full_o), .irq_o(irq_o), .ch_full_o(ch_full_o), .bad_len_o(bad_len_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] exp_mem [2][1024];
  bit          exp_vld [2][1024];
  int          m_cur = 0;
  bit [1:0]    m_full = 2'b00;
  int          m_p = 0;
  int          m_w = 34;
  int          fid = 0;

  // scoreboard
  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic        rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend && q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(rd_data === e, t, rd_data, e);
    end
  end

  function automatic logic [7:0] fbyte(input int f, input int k);
    return 8'(f * 13 + k * 3 + 1);
  endfunction

  task automatic send_frame(input int len, input bit do_clr, input bit clr_s);
    bit ebad = 0, eirq = 0, echf = 0;
    bit [1:0] cm;
    bit [1:0] eff;
    int nw;
    logic s_irq, s_chf, s_bad;
    cm  = do_clr ? (clr_s ? 2'b10 : 2'b01) : 2'b00;
    eff = m_full & ~cm;
    nw  = (len + 3) / 4;
    if (len < 64 || len > 1538) begin
      ebad = 1;
    end else begin
      if (!eff[m_cur] && (m_w + nw > 1024 || m_p >= 66)) begin
        exp_mem[m_cur][0] = {16'(m_w), 16'(m_p)};
        exp_vld[m_cur][0] = 1;
        eff[m_cur] = 1;
        eirq = 1;
        m_cur ^= 1;
        m_p = 0;
        m_w = 34;
        for (int a = 0; a < 1024; a++) exp_vld[m_cur][a] = 0;
      end
      if (eff[m_cur]) begin
        echf = 1;
      end else begin
        int la = 1 + m_p / 2;
        if (m_p % 2 == 0) exp_mem[m_cur][la] = {16'(len), 16'h0};
        else exp_mem[m_cur][la][15:0] = 16'(len);
        exp_vld[m_cur][la] = 1;
        for (int k = 0; k < len; k++) begin
          int wi = m_w + k / 4;
          if (k % 4 == 0) exp_mem[m_cur][wi] = 32'h0;
          exp_mem[m_cur][wi][8*(k%4) +: 8] = fbyte(fid, k);
          exp_vld[m_cur][wi] = 1;
        end
        m_p++;
        m_w += nw;
      end
    end
    m_full = eff;
    s_irq = 0; s_chf = 0; s_bad = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 1) begin
        s_irq = irq_o; s_chf = ch_full_o; s_bad = bad_len_o;
        clr_valid = 1'b0;
      end
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_eof   = (k == len - 1);
      in_byte  = fbyte(fid, k);
      in_len   = 11'(len);
      if (k == 0 && do_clr) begin clr_valid = 1'b1; clr_sel = clr_s; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(s_irq == eirq, "R5 irq pulse", 32'(s_irq), 32'(eirq));
    chk(s_chf == echf, "R7 ch_full pulse", 32'(s_chf), 32'(echf));
    chk(s_bad == ebad, "R6 bad_len pulse", 32'(s_bad), 32'(ebad));
    chk(full_o == m_full, "R4 R8 full bits", 32'(full_o), 32'(m_full));
    fid++;
  endtask

  task automatic sw_clear(input bit s);
    @(negedge clk);
    clr_valid = 1'b1; clr_sel = s;
    @(negedge clk);
    clr_valid = 1'b0;
    m_full[s] = 1'b0;
    chk(full_o == m_full, "R8 clear", 32'(full_o), 32'(m_full));
  endtask

  task automatic check_container(input int c);
    for (int a = 0; a < 1024; a++) begin
      if (exp_vld[c][a]) begin
        @(negedge clk);
        rd_en = 1'b1; rd_sel = c[0]; rd_addr = 10'(a);
        q_exp.push_back(exp_mem[c][a]);
        if (a == 0) q_tag.push_back("R4 R9 summary word");
        else if (a < 34) q_tag.push_back("R3 R9 length table");
        else q_tag.push_back("R2 R9 packed data");
      end
    end
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_byte = 0; in_len = 0;
    clr_valid = 0; clr_sel = 0; rd_en = 0; rd_sel = 0; rd_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full_o == 2'b00, "R1 reset full bits", 32'(full_o), 0);
    chk({irq_o, ch_full_o, bad_len_o} == 3'b000, "R1 reset pulses",
        32'({irq_o, ch_full_o, bad_len_o}), 0);

    // container 0: fill to exactly 1024 words
    send_frame(1538, 0, 0);
    send_frame(65, 0, 0);
    send_frame(1538, 0, 0);
    send_frame(812, 0, 0);
    chk(full_o == 2'b00, "R4 exact fit stays open", 32'(full_o), 0);
    // closes container 0, goes to container 1 (R10)
    send_frame(64, 0, 0);
    check_container(0);

    // illegal lengths (R6)
    send_frame(63, 0, 0);
    send_frame(1539, 0, 0);

    // fill container 1 to 61 frames, then close with both full
    for (int i = 0; i < 60; i++) send_frame(64, 0, 0);
    send_frame(64, 0, 0);   // R5 and R7 in the same cycle
    send_frame(100, 0, 0);  // R7 drop only
    check_container(1);

    // release container 0; alternation resumes at 0 (R10)
    sw_clear(0);
    send_frame(1538, 0, 0);
    send_frame(1538, 0, 0);
    // closing frame with a same-cycle clear of container 1 (R8)
    send_frame(1538, 1, 1);
    check_container(0);
    check_container(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule